// File: doc/BRIEF.md
# SPI Slave Configuration Command Port

This block is the target end of a serial configuration link for a programmable device. A host drives SPI mode 0: the clock idles low, MOSI is sampled on the rising edge and MISO changes on the falling edge. Each frame starts when the active-low chip select falls. The first byte is an opcode and the next three bytes are stuffing. When the fourth byte completes, the command takes effect. Depending on the opcode, the block then shifts a 32-bit word out on MISO, updates its internal write-enable, clear and done state, or passes the following bytes out as a configuration data stream.

The SPI pins are brought into the system clock domain through a synchronizer and sampled there. SCK must therefore run at no more than one eighth of the system clock. A second input reports that configuration has completed; a rising edge on it raises the done flag in the status word. The data stream leaves the block as a byte with a one-cycle valid strobe and no back-pressure.

Top module: `spi_cfg_port`

## Requirements
- R1: Opcode 0x07, followed by three stuffing bytes of any value, makes MISO carry the 32-bit DEVICE_ID, most significant bit first, during SCK rising edges 33 to 64 of the frame. MISO reads 0 during the first 32 bits.
- R2: Opcode 0x09, with the same framing, shifts out the status word captured when the fourth byte completes. Bit 16 is the cleared flag, bit 14 is the done flag, and all other bits are 0.
- R3: Opcode 0x70 takes effect only while writes are enabled. It clears the done flag and holds the cleared flag at 0 for CLEAR_CYCLES clocks, after which the status word reads exactly 0x00010000. While writes are disabled it is ignored.
- R4: Opcode 0x71 clears both the cleared flag and the done flag.
- R5: Opcode 0x4A enables writes and opcode 0x4F disables them. Writes are disabled after reset.
- R6: Opcode 0x41 with writes enabled emits every byte from the fifth byte of the frame onward, in order, each with a single-cycle dataValid pulse. Any emitted data byte clears the cleared flag.
- R7: Opcode 0x41 while writes are disabled emits no data bytes.
- R8: A rising edge on cfgDone sets the done flag (status 0x00004000).
- R9: Raising spiCsN aborts the frame. A command cut short before its fourth byte completes has no effect, a partial data byte is discarded, MISO returns to 0, and the next frame starts again with opcode reception.
- R10: Any other opcode is ignored for the whole frame: no data is emitted, MISO stays 0 and the status is unchanged.
- R11: After reset, MISO and dataValid are 0 and the status word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiCsN | input | 1 | SPI chip select, active low |
| spiSck | input | 1 | SPI clock, mode 0 |
| spiMosi | input | 1 | Serial data from host |
| spiMiso | output | 1 | Serial data to host |
| cfgDone | input | 1 | Configuration-complete indication, rising edge sets done flag |
| dataByte | output | 8 | Configuration data byte |
| dataValid | output | 1 | One-cycle strobe qualifying dataByte |

## Verification
A data byte appears about four system clocks after the eighth rising SCK edge of its byte: two synchronizer stages, edge detection, the byte register and the output register. The bench records every dataValid pulse with a monitor and compares the recorded bytes only after chip select has risen, so the check does not depend on that exact latency. A read word is staged at the end of the fourth byte and loaded on the following falling SCK edge. The bench therefore samples MISO just as it raises SCK for bits 33 to 64, and it also samples bits 1 to 32, which must read 0. The clear delay is counted from the completion of the clear frame's fourth byte. The bench polls status once about 280 clocks later, which falls inside the 600-cycle window and must read 0, and again more than 700 clocks later, which must read 0x00010000.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int STUFF_BYTES = 3;

  localparam logic [BYTE_W-1:0] OP_READ_ID   = 8'h07;
  localparam logic [BYTE_W-1:0] OP_READ_STAT = 8'h09;
  localparam logic [BYTE_W-1:0] OP_CLEAR     = 8'h70;
  localparam logic [BYTE_W-1:0] OP_REFRESH   = 8'h71;
  localparam logic [BYTE_W-1:0] OP_WR_ENABLE = 8'h4A;
  localparam logic [BYTE_W-1:0] OP_WR_DISABL = 8'h4F;
  localparam logic [BYTE_W-1:0] OP_WR_INCR   = 8'h41;

  localparam int CLEARED_BIT = 16;
  localparam int DONE_BIT    = 14;

  typedef struct packed {
    logic loadId;
    logic loadStatus;
    logic emit;
  } ctl_strobe_t;

  typedef enum logic [1:0] {
    ST_OPCODE,
    ST_STUFF,
    ST_STREAM,
    ST_IGNORE
  } frame_state_t;

  function automatic logic isKnownOp(input logic [BYTE_W-1:0] op);
    return (op == OP_READ_ID) || (op == OP_READ_STAT) || (op == OP_CLEAR) ||
           (op == OP_REFRESH) || (op == OP_WR_ENABLE) || (op == OP_WR_DISABL) ||
           (op == OP_WR_INCR);
  endfunction

endpackage

// File: rtl/cfgport_sync.sv
module cfgport_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VALUE = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RESET_VALUE;
        else       stage[g] <= dIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RESET_VALUE;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign dOut = stage[STAGES-1];

endmodule

// File: rtl/cfgport_datapath.sv
module cfgport_datapath
  import cfgport_pkg::*;
#(
  parameter logic [WORD_W-1:0] DEVICE_ID = 32'hC2088080,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiCsN,
  input  logic              spiSck,
  input  logic              spiMosi,
  input  ctl_strobe_t       ctl,
  input  logic [WORD_W-1:0] statusWord,
  output logic              spiMiso,
  output logic              frameIdle,
  output logic              byteDone,
  output logic [BYTE_W-1:0] rxByte,
  output logic [BYTE_W-1:0] dataByte,
  output logic              dataValid
);

  localparam int BIT_CNT_W = $clog2(BYTE_W);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

  logic csS, sckS, mosiS;
  logic sckPrev;
  logic sckRise, sckFall;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] rxShift;
  logic [WORD_W-1:0] txStage, txReg;
  logic txArmed;

  cfgport_sync #(
    .WIDTH(3),
    .STAGES(SYNC_STAGES),
    .RESET_VALUE(3'b100)
  ) spiSync_i (
    .clk  (clk),
    .rstN (rstN),
    .dIn  ({spiCsN, spiSck, spiMosi}),
    .dOut ({csS, sckS, mosiS})
  );

  assign sckRise   = sckS & ~sckPrev & ~csS;
  assign sckFall   = ~sckS & sckPrev & ~csS;
  assign frameIdle = csS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sckS;
  end

  // receive shifter and byte framing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxShift  <= '0;
      rxByte   <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (csS) begin
        bitCnt <= '0;
      end else if (sckRise) begin
        bitCnt  <= bitCnt + 1'b1;
        rxShift <= {rxShift[BYTE_W-2:0], mosiS};
        if (bitCnt == LAST_BIT) begin
          rxByte   <= {rxShift[BYTE_W-2:0], mosiS};
          byteDone <= 1'b1;
        end
      end
    end
  end

  // transmit word: staged on command completion, loaded on next falling edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txStage <= '0;
      txReg   <= '0;
      txArmed <= 1'b0;
    end else if (csS) begin
      txReg   <= '0;
      txArmed <= 1'b0;
    end else begin
      if (ctl.loadId) begin
        txStage <= DEVICE_ID;
        txArmed <= 1'b1;
      end else if (ctl.loadStatus) begin
        txStage <= statusWord;
        txArmed <= 1'b1;
      end
      if (sckFall) begin
        if (txArmed) begin
          txReg   <= txStage;
          txArmed <= 1'b0;
        end else begin
          txReg <= {txReg[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  assign spiMiso = txReg[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataByte  <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= ctl.emit;
      if (ctl.emit) dataByte <= rxByte;
    end
  end

  p_miso_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (csS && $past(csS)) |-> !spiMiso);

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

endmodule

// File: rtl/cfgport_control.sv
module cfgport_control
  import cfgport_pkg::*;
#(
  parameter int CLEAR_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameIdle,
  input  logic              byteDone,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              cfgDone,
  output ctl_strobe_t       ctl,
  output logic [WORD_W-1:0] statusWord
);

  localparam int CLR_W = $clog2(CLEAR_CYCLES + 1);
  localparam logic [CLR_W-1:0] CLR_LOAD = CLR_W'(CLEAR_CYCLES);
  localparam logic [CLR_W-1:0] CLR_ONE  = CLR_W'(1);
  localparam int IDX_W = $clog2(STUFF_BYTES + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(STUFF_BYTES);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

  frame_state_t state;
  logic [BYTE_W-1:0] opcode;
  logic [IDX_W-1:0] byteIdx;
  logic [CLR_W-1:0] clearCnt;
  logic writeEn, cleared, doneFlag;
  logic cfgS, cfgPrev, cfgRise;
  logic finishCmd, doClear, doRefresh, doWen, doWdis, openStream;

  cfgport_sync #(
    .WIDTH(1),
    .STAGES(SYNC_STAGES),
    .RESET_VALUE(1'b0)
  ) doneSync_i (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (cfgDone),
    .dOut (cfgS)
  );

  assign cfgRise = cfgS & ~cfgPrev;

  always_comb begin
    finishCmd      = byteDone && !frameIdle && (state == ST_STUFF) && (byteIdx == IDX_LAST);
    doClear        = finishCmd && (opcode == OP_CLEAR) && writeEn;
    doRefresh      = finishCmd && (opcode == OP_REFRESH);
    doWen          = finishCmd && (opcode == OP_WR_ENABLE);
    doWdis         = finishCmd && (opcode == OP_WR_DISABL);
    openStream     = finishCmd && (opcode == OP_WR_INCR) && writeEn;
    ctl.loadId     = finishCmd && (opcode == OP_READ_ID);
    ctl.loadStatus = finishCmd && (opcode == OP_READ_STAT);
    ctl.emit       = byteDone && !frameIdle && (state == ST_STREAM);
  end

  // frame decoder
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_OPCODE;
      opcode  <= '0;
      byteIdx <= '0;
    end else if (frameIdle) begin
      state   <= ST_OPCODE;
      byteIdx <= '0;
    end else if (byteDone) begin
      unique case (state)
        ST_OPCODE: begin
          opcode  <= rxByte;
          byteIdx <= IDX_ONE;
          state   <= isKnownOp(rxByte) ? ST_STUFF : ST_IGNORE;
        end
        ST_STUFF: begin
          if (byteIdx == IDX_LAST) state <= openStream ? ST_STREAM : ST_IGNORE;
          else                     byteIdx <= byteIdx + IDX_ONE;
        end
        ST_STREAM: state <= ST_STREAM;
        ST_IGNORE: state <= ST_IGNORE;
        default:   state <= ST_IGNORE;
      endcase
    end
  end

  // device state flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeEn  <= 1'b0;
      clearCnt <= '0;
      cleared  <= 1'b0;
      doneFlag <= 1'b0;
      cfgPrev  <= 1'b0;
    end else begin
      cfgPrev <= cfgS;
      if (doWen)       writeEn <= 1'b1;
      else if (doWdis) writeEn <= 1'b0;

      if (doClear)               clearCnt <= CLR_LOAD;
      else if (clearCnt != '0)   clearCnt <= clearCnt - CLR_ONE;

      if (doClear || doRefresh || ctl.emit) cleared <= 1'b0;
      else if (clearCnt == CLR_ONE)         cleared <= 1'b1;

      if (doClear || doRefresh) doneFlag <= 1'b0;
      else if (cfgRise)         doneFlag <= 1'b1;
    end
  end

  always_comb begin
    statusWord              = '0;
    statusWord[CLEARED_BIT] = cleared;
    statusWord[DONE_BIT]    = doneFlag;
  end

  p_cleared_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    (clearCnt != '0) |-> !cleared);

  p_strobe_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadId, ctl.loadStatus, ctl.emit}));

  p_stream_needs_wen_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.emit |-> writeEn);

  p_done_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRise && !doClear && !doRefresh) |=> doneFlag);

  p_refresh_drops_r4: assert property (@(posedge clk) disable iff (!rstN)
    doRefresh |=> (!cleared && !doneFlag));

endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import cfgport_pkg::*;
#(
  parameter logic [31:0] DEVICE_ID = 32'hC2088080,
  parameter int CLEAR_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiCsN,
  input  logic       spiSck,
  input  logic       spiMosi,
  output logic       spiMiso,
  input  logic       cfgDone,
  output logic [7:0] dataByte,
  output logic       dataValid
);

  ctl_strobe_t ctl;
  logic [WORD_W-1:0] statusWord;
  logic frameIdle, byteDone;
  logic [BYTE_W-1:0] rxByte;

  cfgport_datapath #(
    .DEVICE_ID(DEVICE_ID),
    .SYNC_STAGES(SYNC_STAGES)
  ) datapath_i (
    .clk        (clk),
    .rstN       (rstN),
    .spiCsN     (spiCsN),
    .spiSck     (spiSck),
    .spiMosi    (spiMosi),
    .ctl        (ctl),
    .statusWord (statusWord),
    .spiMiso    (spiMiso),
    .frameIdle  (frameIdle),
    .byteDone   (byteDone),
    .rxByte     (rxByte),
    .dataByte   (dataByte),
    .dataValid  (dataValid)
  );

  cfgport_control #(
    .CLEAR_CYCLES(CLEAR_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) control_i (
    .clk        (clk),
    .rstN       (rstN),
    .frameIdle  (frameIdle),
    .byteDone   (byteDone),
    .rxByte     (rxByte),
    .cfgDone    (cfgDone),
    .ctl        (ctl),
    .statusWord (statusWord)
  );

endmodule

// File: tb/spi_cfg_port_tb_top.sv
module spi_cfg_port_tb_top;

  localparam logic [31:0] ID = 32'hC2088080;
  localparam int CLR = 600;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiCsN = 1'b1;
  logic spiSck = 1'b0;
  logic spiMosi = 1'b0;
  logic cfgDone = 1'b0;
  logic spiMiso;
  logic [7:0] dataByte;
  logic dataValid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] txBuf [0:299];
  logic [7:0] rxBuf [0:299];
  logic [7:0] capBuf [0:511];
  int capCnt = 0;

  always #4 clk = ~clk;

  spi_cfg_port #(.DEVICE_ID(ID), .CLEAR_CYCLES(CLR)) dut_i (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .cfgDone(cfgDone), .dataByte(dataByte), .dataValid(dataValid)
  );

  always @(negedge clk) begin
    if (dataValid && capCnt < 512) begin
      capBuf[capCnt] = dataByte;
      capCnt = capCnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic halfWait();
    repeat (4) @(negedge clk);
  endtask

  task automatic sendBits(input int nBits);
    for (int i = 0; i < 300; i++) rxBuf[i] = 8'h00;
    spiCsN = 1'b0;
    halfWait();
    halfWait();
    for (int i = 0; i < nBits; i++) begin
      spiMosi = txBuf[i / 8][7 - (i % 8)];
      halfWait();
      spiSck = 1'b1;
      rxBuf[i / 8][7 - (i % 8)] = spiMiso;
      halfWait();
      spiSck = 1'b0;
    end
    halfWait();
    spiCsN = 1'b1;
    spiMosi = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cmd4(input logic [7:0] op);
    txBuf[0] = op; txBuf[1] = 8'h00; txBuf[2] = 8'h00; txBuf[3] = 8'h00;
    sendBits(32);
  endtask

  task automatic readWord(input logic [7:0] op, input logic [7:0] stuff, output logic [31:0] w);
    txBuf[0] = op;
    for (int i = 1; i < 4; i++) txBuf[i] = stuff;
    for (int i = 4; i < 8; i++) txBuf[i] = 8'h00;
    sendBits(64);
    w = {rxBuf[4], rxBuf[5], rxBuf[6], rxBuf[7]};
  endtask

  task automatic loadStream(input int n, input int seed);
    txBuf[0] = 8'h41; txBuf[1] = 8'hFF; txBuf[2] = 8'hFF; txBuf[3] = 8'hFF;
    for (int i = 0; i < n; i++) txBuf[4 + i] = 8'((i * seed + 3) & 255);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    int base;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset state
    chk("R11 miso after reset", {31'd0, spiMiso}, 32'd0);
    chk("R11 dataValid after reset", {31'd0, dataValid}, 32'd0);

    // R1 identifier read with two stuffing patterns
    readWord(8'h07, 8'h00, w);
    chk("R1 id word", w, ID);
    chk("R1 miso zero in first 32 bits", {rxBuf[0], rxBuf[1], rxBuf[2], rxBuf[3]}, 32'd0);
    readWord(8'h07, 8'hFF, w);
    chk("R1 id word ff stuffing", w, ID);

    readWord(8'h09, 8'h00, w);
    chk("R11 status after reset", w, 32'h0);

    // R7 stream while disabled
    base = capCnt;
    loadStream(4, 7);
    sendBits(8 * 8);
    chk("R7 no bytes when disabled", capCnt - base, 0);

    // R3 clear ignored while disabled
    cmd4(8'h70);
    repeat (1000) @(negedge clk);
    readWord(8'h09, 8'h00, w);
    chk("R3 clear ignored while disabled", w, 32'h0);

    // R3 proper clear sequence
    cmd4(8'h71);
    cmd4(8'h4A);
    cmd4(8'h70);
    readWord(8'h09, 8'h00, w);
    chk("R3 cleared flag low while clearing", w, 32'h0);
    repeat (700) @(negedge clk);
    readWord(8'h09, 8'h00, w);
    chk("R2 R3 status after clear", w, 32'h0001_0000);

    // R6 exhaustive byte stream 0..255
    base = capCnt;
    txBuf[0] = 8'h41; txBuf[1] = 8'hFF; txBuf[2] = 8'hFF; txBuf[3] = 8'hFF;
    for (int i = 0; i < 256; i++) txBuf[4 + i] = 8'(i);
    sendBits(260 * 8);
    chk("R6 stream byte count", capCnt - base, 256);
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) if (capBuf[base + i] !== 8'(i)) bad++;
      chk("R6 stream byte values mismatches", bad, 0);
    end
    readWord(8'h09, 8'h00, w);
    chk("R6 data drops cleared flag", w, 32'h0);

    // R8 done flag
    cfgDone = 1'b1;
    repeat (10) @(negedge clk);
    readWord(8'h09, 8'h00, w);
    chk("R8 done flag set", w, 32'h0000_4000);
    cmd4(8'h70);
    repeat (700) @(negedge clk);
    readWord(8'h09, 8'h00, w);
    chk("R3 clear drops done", w, 32'h0001_0000);
    cfgDone = 1'b0;
    repeat (10) @(negedge clk);
    cfgDone = 1'b1;
    repeat (10) @(negedge clk);
    readWord(8'h09, 8'h00, w);
    chk("R8 done with cleared", w, 32'h0001_4000);

    // R4 refresh
    cmd4(8'h71);
    readWord(8'h09, 8'h00, w);
    chk("R4 refresh drops flags", w, 32'h0);

    // R5 disable
    cmd4(8'h4F);
    base = capCnt;
    loadStream(3, 11);
    sendBits(7 * 8);
    chk("R5 no bytes after disable", capCnt - base, 0);

    // R9 aborted enable frame
    txBuf[0] = 8'h4A; txBuf[1] = 8'h00; txBuf[2] = 8'h00;
    sendBits(20);
    base = capCnt;
    loadStream(3, 13);
    sendBits(7 * 8);
    chk("R9 aborted enable has no effect", capCnt - base, 0);

    // R9 aborted read, then full read decodes afresh
    txBuf[0] = 8'h07; txBuf[1] = 8'h00; txBuf[2] = 8'h00; txBuf[3] = 8'h00;
    txBuf[4] = 8'h00;
    sendBits(40);
    readWord(8'h07, 8'h00, w);
    chk("R9 read after aborted read", w, ID);

    // R9 partial data byte discarded; R5 enable
    cmd4(8'h4A);
    base = capCnt;
    txBuf[0] = 8'h41; txBuf[1] = 8'hFF; txBuf[2] = 8'hFF; txBuf[3] = 8'hFF;
    txBuf[4] = 8'hAA; txBuf[5] = 8'hBB;
    sendBits(5 * 8 + 4);
    chk("R9 partial byte dropped count", capCnt - base, 1);
    chk("R9 full byte kept", {24'd0, capBuf[base]}, 32'h0000_00AA);
    base = capCnt;
    loadStream(2, 29);
    sendBits(6 * 8);
    chk("R5 enable allows stream", capCnt - base, 2);
    chk("R5 stream byte 1", {24'd0, capBuf[base + 1]}, 32'((1 * 29 + 3) & 255));

    // R10 unknown opcode
    base = capCnt;
    txBuf[0] = 8'h55; txBuf[1] = 8'h41; txBuf[2] = 8'hFF; txBuf[3] = 8'hFF;
    txBuf[4] = 8'hFF; txBuf[5] = 8'h11; txBuf[6] = 8'h22; txBuf[7] = 8'h33;
    sendBits(64);
    chk("R10 unknown opcode no bytes", capCnt - base, 0);
    chk("R10 miso quiet", {rxBuf[4], rxBuf[5], rxBuf[6], rxBuf[7]}, 32'd0);
    readWord(8'h09, 8'h00, w);
    chk("R10 status unchanged", w, 32'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule